// File: doc/BRIEF.md
# DDR2 Write Burst Strobe Sequencer

This block is the controller-side sequencer that turns one accepted write request into a timed command pulse, a data-strobe waveform and a burst on the data lanes. A request carries the bank, the column, an auto-precharge choice, a burst-length choice, a strobe skew code, the latency configuration and the whole write burst packed into one vector. The block runs on a fast clock at twice the memory clock, so each fast cycle is one half of a memory clock. This lets one register stage model each double-data-rate edge.

After a request is accepted, the block waits the write latency. The write latency is the CAS latency plus the additive latency, minus one memory clock. The block then drives the strobe low for a full memory clock as a preamble, sends the data beats with the strobe alternating high and low, and holds the strobe low for half a memory clock as a postamble. At the end it releases the strobe and the data lanes together. If auto-precharge was requested, a precharge-pending pulse marks the end of the burst. A latency configuration outside the supported range is refused with an error pulse.

Top module: `ddr2_wseq`

## Requirements
- R1: The write latency in memory clocks is WL = CL + AL - 1. The first fast cycle with the strobe high comes exactly 2*WL fast cycles after the fast cycle in which `cmd_we_o` is high.
- R2: `cmd_we_o` is high for exactly one fast cycle, the cycle after the edge that accepts a request (`req_valid_i` high while `req_ready_o` is high). In that cycle `cmd_bank_o`, `cmd_col_o` and `cmd_ap_o` carry the values presented with the request.
- R3: For the two fast cycles just before the first strobe-high cycle, `dqs_oe_o` is 1, `dqs_o` is 0 and `dq_oe_o` is 0. This is the preamble.
- R4: Beat k of the burst is taken from `req_data_i[k*DQ_W +: DQ_W]` and is driven on `dq_o` in the k-th fast cycle from the first strobe-high cycle. In that cycle `dqs_o` is 1 for even k and 0 for odd k. The burst has 8 beats when `req_bl8_i` is 1 and 4 beats when it is 0.
- R5: The fast cycle after the last beat is the postamble: `dqs_oe_o`=1, `dqs_o`=0, `dq_oe_o`=1, `dq_o`=0. In the next cycle both output enables are 0. The two enables go low in the same cycle.
- R6: `ap_pend_o` is high in the postamble cycle when the request had auto-precharge set, and is low at all other times.
- R7: `req_ready_o` is 0 from the command cycle through the postamble and returns to 1 in the cycle after the postamble. A request offered while `req_ready_o` is 0 produces no command. Changes on `req_data_i` after acceptance do not alter the beats driven. Outside a burst both output enables are 0.
- R8: Whenever `dqs_oe_o` is 1, `dqs_skew_o` holds the skew code captured with the request: 0 means nominal, 1 means a quarter clock early, 2 means a quarter clock late, and 3 is treated as 0.
- R9: A request with CL outside 3..6, AL above 4, or a write latency below 1 produces a one-cycle `err_o` pulse in the cycle after the edge, no command, and `req_ready_o` stays 1.
- R10: While reset is high and in the cycle after it is released, `req_ready_o`=1 and `cmd_we_o`, `dqs_oe_o`, `dq_oe_o`, `ap_pend_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the memory clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Write request offered |
| req_ready_o | output | 1 | Sequencer idle, a request can be accepted |
| req_bank_i | input | BANK_W | Starting bank |
| req_col_i | input | COL_W | Starting column |
| req_ap_i | input | 1 | Auto-precharge requested |
| req_bl8_i | input | 1 | 1 selects a burst of 8, 0 a burst of 4 |
| req_skew_i | input | 2 | Strobe placement code |
| cas_lat_i | input | 3 | CAS latency in memory clocks |
| add_lat_i | input | 3 | Additive latency in memory clocks |
| req_data_i | input | MAX_BL*DQ_W | Burst data, beat k at bits k*DQ_W |
| cmd_we_o | output | 1 | Write command pulse |
| cmd_bank_o | output | BANK_W | Command bank |
| cmd_col_o | output | COL_W | Command column |
| cmd_ap_o | output | 1 | Command auto-precharge flag |
| dqs_o | output | 1 | Strobe level |
| dqs_oe_o | output | 1 | Strobe output enable |
| dqs_skew_o | output | 2 | Strobe placement code for the delay stage |
| dq_o | output | DQ_W | Data lanes |
| dq_oe_o | output | 1 | Data output enable |
| ap_pend_o | output | 1 | Precharge pending at burst end |
| err_o | output | 1 | Latency configuration refused |

## Verification
The bench builds the block with its default parameters: 8 data lanes, a largest burst of 8 and a 5-bit latency counter. The counter width covers the full wait at CL 6 with AL 4, a write latency of 9. Runs at CL 3 with AL 0 make the wait a single fast cycle, the tightest gap between the command and the preamble. Runs at the top of the latency range use the largest counter load. Both burst lengths, every skew code and back-to-back requests are driven, so the return to ready right after the postamble is exercised.

// File: rtl/ddr2_wseq_pkg.sv
package ddr2_wseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_CMD   = 3'd1,
    S_WAIT  = 3'd2,
    S_PRE   = 3'd3,
    S_BURST = 3'd4,
    S_POST  = 3'd5
  } wstate_e;

  localparam int unsigned CL_MIN = 3;
  localparam int unsigned CL_MAX = 6;
  localparam int unsigned AL_MAX = 4;
endpackage

// File: rtl/ddr2_wl_calc.sv
module ddr2_wl_calc
  import ddr2_wseq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [2:0]       cas_lat_i,
  input  logic [2:0]       add_lat_i,
  output logic             cfg_ok_o,
  output logic [CNT_W-1:0] wait_ld_o
);
  logic [4:0] rl;
  logic [4:0] wl;
  logic [5:0] half_cycles;

  always_comb begin
    rl = {2'b00, cas_lat_i} + {2'b00, add_lat_i};
    wl = rl - 5'd1;
    cfg_ok_o = (cas_lat_i >= 3'(CL_MIN)) && (cas_lat_i <= 3'(CL_MAX)) &&
               (add_lat_i <= 3'(AL_MAX)) && (rl >= 5'd2);
    // fast cycles spent in the wait state, minus one for the down-counter
    half_cycles = {wl, 1'b0} - 6'd4;
    wait_ld_o = cfg_ok_o ? CNT_W'(half_cycles) : '0;
  end
endmodule

// File: rtl/ddr2_beat_sel.sv
module ddr2_beat_sel #(
  parameter int DQ_W   = 8,
  parameter int MAX_BL = 8,
  localparam int IDX_W = $clog2(MAX_BL)
) (
  input  logic [MAX_BL*DQ_W-1:0] burst_i,
  input  logic [IDX_W-1:0]       idx_i,
  output logic [DQ_W-1:0]        beat_o
);
  logic [DQ_W-1:0] beats [MAX_BL];

  for (genvar g = 0; g < MAX_BL; g++) begin : g_unpack
    assign beats[g] = burst_i[g*DQ_W +: DQ_W];
  end

  assign beat_o = beats[idx_i];
endmodule

// File: rtl/ddr2_wseq.sv
module ddr2_wseq
  import ddr2_wseq_pkg::*;
#(
  parameter int DQ_W   = 8,
  parameter int MAX_BL = 8,
  parameter int BANK_W = 3,
  parameter int COL_W  = 10,
  parameter int CNT_W  = 5,
  localparam int IDX_W = $clog2(MAX_BL),
  localparam int DW    = MAX_BL * DQ_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_ap_i,
  input  logic              req_bl8_i,
  input  logic [1:0]        req_skew_i,
  input  logic [2:0]        cas_lat_i,
  input  logic [2:0]        add_lat_i,
  input  logic [DW-1:0]     req_data_i,
  output logic              cmd_we_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [COL_W-1:0]  cmd_col_o,
  output logic              cmd_ap_o,
  output logic              dqs_o,
  output logic              dqs_oe_o,
  output logic [1:0]        dqs_skew_o,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o,
  output logic              ap_pend_o,
  output logic              err_o
);
  wstate_e          state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] beat_q, beat_d;
  logic [CNT_W-1:0] wait_ld, wait_ld_q;
  logic             cfg_ok;
  logic             bl8_q;
  logic [DW-1:0]    burst_q;
  logic             accept_ok, accept_bad;
  logic [DQ_W-1:0]  beat_val;
  logic [IDX_W-1:0] last_beat;

  ddr2_wl_calc #(.CNT_W(CNT_W)) u_wl (
    .cas_lat_i (cas_lat_i),
    .add_lat_i (add_lat_i),
    .cfg_ok_o  (cfg_ok),
    .wait_ld_o (wait_ld)
  );

  ddr2_beat_sel #(.DQ_W(DQ_W), .MAX_BL(MAX_BL)) u_sel (
    .burst_i (burst_q),
    .idx_i   (beat_d),
    .beat_o  (beat_val)
  );

  assign last_beat  = bl8_q ? IDX_W'(MAX_BL - 1) : IDX_W'(3);
  assign accept_ok  = (state_q == S_IDLE) && req_valid_i && cfg_ok;
  assign accept_bad = (state_q == S_IDLE) && req_valid_i && !cfg_ok;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    beat_d  = beat_q;
    unique case (state_q)
      S_IDLE:  if (accept_ok) state_d = S_CMD;
      S_CMD: begin
        state_d = S_WAIT;
        cnt_d   = wait_ld_q;
      end
      S_WAIT: begin
        if (cnt_q == '0) begin
          state_d = S_PRE;
          cnt_d   = CNT_W'(1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      S_PRE: begin
        if (cnt_q == '0) begin
          state_d = S_BURST;
          beat_d  = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      S_BURST: begin
        if (beat_q == last_beat) state_d = S_POST;
        else                     beat_d  = beat_q + 1'b1;
      end
      S_POST:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      cnt_q       <= '0;
      beat_q      <= '0;
      wait_ld_q   <= '0;
      bl8_q       <= 1'b0;
      burst_q     <= '0;
      cmd_bank_o  <= '0;
      cmd_col_o   <= '0;
      cmd_ap_o    <= 1'b0;
      dqs_skew_o  <= 2'd0;
      req_ready_o <= 1'b1;
      cmd_we_o    <= 1'b0;
      dqs_o       <= 1'b0;
      dqs_oe_o    <= 1'b0;
      dq_o        <= '0;
      dq_oe_o     <= 1'b0;
      ap_pend_o   <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      beat_q  <= beat_d;
      if (accept_ok) begin
        wait_ld_q  <= wait_ld;
        bl8_q      <= req_bl8_i;
        burst_q    <= req_data_i;
        cmd_bank_o <= req_bank_i;
        cmd_col_o  <= req_col_i;
        cmd_ap_o   <= req_ap_i;
        dqs_skew_o <= (req_skew_i == 2'd3) ? 2'd0 : req_skew_i;
      end
      req_ready_o <= (state_d == S_IDLE);
      cmd_we_o    <= (state_d == S_CMD);
      dqs_oe_o    <= (state_d == S_PRE) || (state_d == S_BURST) || (state_d == S_POST);
      dqs_o       <= (state_d == S_BURST) && !beat_d[0];
      dq_oe_o     <= (state_d == S_BURST) || (state_d == S_POST);
      dq_o        <= (state_d == S_BURST) ? beat_val : '0;
      ap_pend_o   <= (state_d == S_POST) && cmd_ap_o;
      err_o       <= accept_bad;
    end
  end
endmodule

// File: rtl/ddr2_wseq_chk.sv
module ddr2_wseq_chk (
  input logic clk,
  input logic rst,
  input logic req_ready_o,
  input logic cmd_we_o,
  input logic dqs_o,
  input logic dqs_oe_o,
  input logic dq_oe_o,
  input logic ap_pend_o,
  input logic err_o
);
  p_cmd_single_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_we_o |=> !cmd_we_o);

  p_pre_low_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(dqs_oe_o) |-> !dqs_o && !dq_oe_o);

  p_first_high_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe_o) |-> dqs_o);

  p_data_needs_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    dq_oe_o |-> dqs_oe_o);

  p_release_together_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(dqs_oe_o) |-> $fell(dq_oe_o));

  p_ap_in_post_r6: assert property (@(posedge clk) disable iff (rst)
    ap_pend_o |-> dqs_oe_o && !dqs_o && dq_oe_o);

  p_ready_idle_r7: assert property (@(posedge clk) disable iff (rst)
    req_ready_o |-> !dqs_oe_o && !cmd_we_o);

  p_err_no_cmd_r9: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !cmd_we_o && req_ready_o);
endmodule

bind ddr2_wseq ddr2_wseq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_ready_o (req_ready_o),
  .cmd_we_o    (cmd_we_o),
  .dqs_o       (dqs_o),
  .dqs_oe_o    (dqs_oe_o),
  .dq_oe_o     (dq_oe_o),
  .ap_pend_o   (ap_pend_o),
  .err_o       (err_o)
);

// File: tb/ddr2_wseq_tb_top.sv
module ddr2_wseq_tb_top;
  localparam int DQ_W = 8, MAX_BL = 8, BANK_W = 3, COL_W = 10;
  localparam int DW = DQ_W * MAX_BL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic req_valid = 1'b0, req_ready, req_ap = 1'b0, req_bl8 = 1'b0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic [1:0] req_skew = 2'd0;
  logic [2:0] cas_lat = 3'd3, add_lat = 3'd0;
  logic [DW-1:0] req_data = '0;
  logic cmd_we, cmd_ap, dqs, dqs_oe, dq_oe, ap_pend, err;
  logic [BANK_W-1:0] cmd_bank;
  logic [COL_W-1:0] cmd_col;
  logic [1:0] dqs_skew;
  logic [DQ_W-1:0] dq;

  ddr2_wseq dut_i (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_bank_i(req_bank), .req_col_i(req_col), .req_ap_i(req_ap),
    .req_bl8_i(req_bl8), .req_skew_i(req_skew), .cas_lat_i(cas_lat),
    .add_lat_i(add_lat), .req_data_i(req_data), .cmd_we_o(cmd_we),
    .cmd_bank_o(cmd_bank), .cmd_col_o(cmd_col), .cmd_ap_o(cmd_ap),
    .dqs_o(dqs), .dqs_oe_o(dqs_oe), .dqs_skew_o(dqs_skew), .dq_o(dq),
    .dq_oe_o(dq_oe), .ap_pend_o(ap_pend), .err_o(err)
  );

  typedef struct {
    int wl; int bl; logic [DW-1:0] data; logic ap;
    logic [BANK_W-1:0] bank; logic [COL_W-1:0] col; logic [1:0] skew;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0, cyc = 0, t0 = 0;
  bit active = 0, done = 0;

  task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare every cycle of a burst with the queue head
  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_we) begin
        if (q.size() == 0 || active) chk(0, "R7", "unexpected command", 1, 0);
        else begin
          chk(cmd_bank == q[0].bank && cmd_col == q[0].col && cmd_ap == q[0].ap, "R2",
              "command fields", {cmd_bank, cmd_col, cmd_ap}, {q[0].bank, q[0].col, q[0].ap});
          t0 = cyc;
          active = 1;
        end
      end
      if (active) begin
        automatic exp_t e = q[0];
        automatic int off = cyc - t0;
        automatic int fr = 2 * e.wl;
        automatic logic [12:0] act = {req_ready, dqs_oe, dqs, dq_oe, ap_pend, dq};
        automatic logic [12:0] ex = '0;
        automatic string rq = "R1";
        if (off >= fr - 2 && off < fr) begin
          ex = {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}; rq = "R3";
        end else if (off >= fr && off < fr + e.bl) begin
          automatic int k = off - fr;
          ex = {1'b0, 1'b1, 1'(k % 2 == 0), 1'b1, 1'b0, e.data[k*DQ_W +: DQ_W]};
          rq = (k == 0) ? "R1" : "R4";
        end else if (off == fr + e.bl) begin
          ex = {1'b0, 1'b1, 1'b0, 1'b1, e.ap, 8'h00}; rq = e.ap ? "R6" : "R5";
        end else if (off == fr + e.bl + 1) begin
          ex = {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}; rq = "R7";
        end
        chk(act == ex, rq, $sformatf("burst cycle %0d", off), 64'(act), 64'(ex));
        if (dqs_oe) chk(dqs_skew == e.skew, "R8", "skew code", 64'(dqs_skew), 64'(e.skew));
        if (off == fr + e.bl + 1) begin
          void'(q.pop_front());
          active = 0;
        end
      end
    end
  end

  task automatic send(int cl, int al, bit bl8, bit ap, int bank, int col, int skew,
                      logic [DW-1:0] data);
    exp_t e;
    while (!req_ready) @(negedge clk);
    cas_lat = 3'(cl); add_lat = 3'(al); req_bl8 = bl8; req_ap = ap;
    req_bank = BANK_W'(bank); req_col = COL_W'(col); req_skew = 2'(skew);
    req_data = data; req_valid = 1'b1;
    e.wl = cl + al - 1; e.bl = bl8 ? 8 : 4; e.data = data; e.ap = ap;
    e.bank = BANK_W'(bank); e.col = COL_W'(col); e.skew = (skew == 3) ? 2'd0 : 2'(skew);
    q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_bad(int cl, int al);
    while (!req_ready) @(negedge clk);
    cas_lat = 3'(cl); add_lat = 3'(al); req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(err == 1'b1, "R9", "error pulse", 64'(err), 1);
    chk(cmd_we == 1'b0 && req_ready == 1'b1, "R9", "no command, still ready",
        {cmd_we, req_ready}, 2'b01);
    req_valid = 1'b0;
    @(negedge clk);
    chk(err == 1'b0, "R9", "error pulse width", 64'(err), 0);
  endtask

  task automatic drain();
    while (q.size() > 0 || active) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({req_ready, cmd_we, dqs_oe, dq_oe, ap_pend, err} == 6'b100000, "R10", "in reset",
        {req_ready, cmd_we, dqs_oe, dq_oe, ap_pend, err}, 6'b100000);
    rst = 1'b0;
    @(negedge clk);
    chk({req_ready, cmd_we, dqs_oe, dq_oe, ap_pend, err} == 6'b100000, "R10", "after reset",
        {req_ready, cmd_we, dqs_oe, dq_oe, ap_pend, err}, 6'b100000);

    send(3, 0, 0, 0, 1, 10'h011, 0, 64'h0000_0000_4433_2211);
    drain();
    send(3, 0, 1, 1, 2, 10'h2a5, 1, 64'h8877_6655_4433_2211);
    drain();
    send(6, 4, 1, 1, 7, 10'h3ff, 2, 64'hf0e1_d2c3_b4a5_9687);
    // request and data changes while busy must be ignored (R7)
    repeat (4) @(negedge clk);
    req_valid = 1'b1; req_data = '1; req_bank = 3'd5;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (6) @(negedge clk);
    req_data = '0;
    drain();
    // back-to-back requests (R7 ready timing)
    send(4, 1, 0, 1, 3, 10'h100, 3, 64'h0000_0000_a5a5_5a5a);
    send(5, 2, 1, 0, 4, 10'h001, 0, 64'h0102_0408_1020_4080);
    drain();
    send_bad(2, 0);
    send_bad(7, 0);
    send_bad(3, 5);
    send(3, 4, 0, 0, 6, 10'h0f0, 2, 64'h0000_0000_dead_beef);
    drain();
    repeat (5) @(negedge clk);
    chk(dqs_oe == 1'b0 && dq_oe == 1'b0, "R7", "lanes released when idle",
        {dqs_oe, dq_oe}, 2'b00);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule